// File: doc/BRIEF.md
# Segmented Companding Successive-Approximation Sequencer

This block is the digital controller of an 8-bit segmented mu-law encoder built on a charge-redistribution capacitor array. Once per sampling frame it runs one conversion. It first acquires the input on the array top plates while every bottom plate sits on the reference. It then reads the comparator to decide the sign. Next it moves the bottom plates to the start position for that sign and finds the chord by moving one capacitor at a time, from the smallest upward. Last, it resolves the four linear step bits by binary successive approximation through a resistor-string tap applied to the chord capacitor.

Bipolar inputs are handled with a single-polarity reference. A positive sample starts with every plate on ground and moves plates toward the reference. A negative sample starts with every plate on the reference, opens the polarity switch and moves plates toward ground. The result leaves the block in transmitted mu-law form, with all bits inverted, together with a one-cycle completion strobe.

Every step gives the switches a fixed number of settle cycles. The comparator is sampled at the last of those cycles. Acquisition length, settle count, chord count, step width, tap resolution and output inversion are all parameters.

Top module: `seg_sar_seq`

## Requirements
- R1: After reset, done and sample_en are 0, code_out is 8'h00, tap_en is 0, pol_sw is 1 and every plate_sel bit is 1 (1 = reference, 0 = ground).
- R2: A frame_tick seen while idle starts a conversion. sample_en is then high for exactly ACQ_CYC (default 4) cycles, and while it is high all plates select the reference and pol_sw is 1.
- R3: The sign is taken from cmp_hi at the end of the sign phase (1 = positive). In the first cycle after the sign phase, a positive sample has all plates at 0 with pol_sw 1, and a negative sample has all plates at 1 with pol_sw 0.
- R4: Between consecutive cycles, the plate vector changes in at most one bit, except for the full flip at the start of a positive search and the return of all plates to the reference. The first chord step moves capacitor 0 alone. A move goes to 1 for a positive sample and to 0 for a negative sample.
- R5: The chord is the index of the capacitor whose move reverses the comparator against the sign. If the comparator never reverses through capacitor 6, the chord is 7.
- R6: The step bits are found most significant first. Each trial drives tap_code = 2 x trial value (out of 32) with tap_en high on tap_cap = chord. A trial bit is kept when the comparator still agrees with the sign. tap_en is high for 4 x SETTLE cycles in each conversion.
- R7: code_out = ~{negative, chord[2:0], step[3:0]} (bit 7 is the sign, bits 6:4 are the chord, bits 3:0 are the step). It changes at the same edge where done rises, and done is high for exactly one cycle.
- R8: done rises ACQ_CYC + SETTLE x (6 + n) clock edges after the edge that captures frame_tick, where n = chord + 1 for chords below 7 and n = 7 for chord 7.
- R9: A frame_tick that arrives during a conversion is ignored. It changes neither the result nor the latency, and no new acquisition follows the conversion.
- R10: code_out holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_tick | input | 1 | One-cycle frame start request |
| cmp_hi | input | 1 | Comparator output, 1 when the sensing node is above the threshold |
| sample_en | output | 1 | Top-plate input sampling switch |
| pol_sw | output | 1 | Polarity switch, 1 = closed |
| plate_sel | output | 8 | Bottom-plate selects per capacitor, 1 = reference, 0 = ground |
| tap_en | output | 1 | Connect the resistor-string tap to the selected capacitor |
| tap_cap | output | 3 | Index of the capacitor that receives the tap |
| tap_code | output | 6 | Tap position k, giving k/32 of the reference |
| done | output | 1 | One-cycle completion strobe |
| code_out | output | 8 | Transmitted (inverted) mu-law code |

## Verification
A comparator model in the bench derives the comparator from the plate, tap and polarity outputs, using a chosen sign, chord and step. Conversions are run for both signs at chord 0, at chords in the middle of the range and at the saturating chord 7, with steps 0, 15 and values in between. Step 0 and step 15 show whether every trial bit is cleared or kept. Opposite signs at the same chord separate the two switching directions. Chord 7 separates saturation from a reversal at the last searched capacitor. The latency measured for each chord confirms the number of search steps. One run injects a frame request during the conversion, to show that the request has no effect on the code, the latency or the following cycles.

// File: rtl/seg_sar_pkg.sv
package seg_sar_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ACQ,
      PH_SIGN,
      PH_SETUP,
      PH_CHORD,
      PH_LIN,
      PH_DONE
   } phase_t;
endpackage

// File: rtl/seg_sar_timer.sv
module seg_sar_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] len_m1,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign expire = run && (cnt_q == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || expire) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/seg_sar_plates.sv
module seg_sar_plates
   import seg_sar_pkg::*;
#(
   parameter int NCHORD = 8,
   parameter int CW     = 3
) (
   input  phase_t            phase,
   input  logic              neg,
   input  logic [CW-1:0]     cidx,
   output logic [NCHORD-1:0] plate_sel,
   output logic              pol_sw
);
   logic searching;
   assign searching = (phase == PH_SETUP) || (phase == PH_CHORD) || (phase == PH_LIN);
   assign pol_sw    = !(neg && searching);

   for (genvar i = 0; i < NCHORD; i++) begin : g_cap
      logic moved;
      always_comb begin
         unique case (phase)
            PH_CHORD: moved = (i <= int'(cidx));
            PH_LIN:   moved = (i <  int'(cidx));
            default:  moved = 1'b0;
         endcase
      end
      // outside the search every plate rests on the reference
      assign plate_sel[i] = searching ? (moved ^ neg) : 1'b1;
   end
endmodule

// File: rtl/seg_sar_linear.sv
module seg_sar_linear #(
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic          keep,
   output logic [SW-1:0] trial,
   output logic [SW-1:0] resolved,
   output logic          last
);
   logic [SW-1:0] acc_q, mask_q;
   localparam logic [SW-1:0] MSB = {1'b1, {(SW-1){1'b0}}};

   assign trial    = acc_q;
   assign resolved = keep ? acc_q : (acc_q & ~mask_q);
   assign last     = mask_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mask_q <= '0;
      end else if (clear) begin
         acc_q  <= MSB;
         mask_q <= MSB;
      end else if (step) begin
         acc_q  <= resolved | (mask_q >> 1);
         mask_q <= mask_q >> 1;
      end
   end
endmodule

// File: rtl/seg_sar_pack.sv
module seg_sar_pack #(
   parameter int CODE_W     = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] raw,
   output logic [CODE_W-1:0] code
);
   logic [CODE_W-1:0] wire_form;

   if (INVERT_OUT) begin : g_inv
      assign wire_form = ~raw;
   end else begin : g_plain
      assign wire_form = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code <= '0;
      else if (load) code <= wire_form;
   end
endmodule

// File: rtl/seg_sar_seq.sv
module seg_sar_seq
   import seg_sar_pkg::*;
#(
   parameter int NCHORD     = 8,
   parameter int SW         = 4,
   parameter int TAP_RES    = 32,
   parameter int ACQ_CYC    = 4,
   parameter int SETTLE     = 2,
   parameter bit INVERT_OUT = 1'b1,
   localparam int CW        = $clog2(NCHORD),
   localparam int TAP_W     = $clog2(TAP_RES + 1),
   localparam int CODE_W    = 1 + CW + SW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              cmp_hi,
   output logic              sample_en,
   output logic              pol_sw,
   output logic [NCHORD-1:0] plate_sel,
   output logic              tap_en,
   output logic [CW-1:0]     tap_cap,
   output logic [TAP_W-1:0]  tap_code,
   output logic              done,
   output logic [CODE_W-1:0] code_out
);
   localparam int TAP_SHIFT = $clog2(TAP_RES) - SW;
   localparam int LONGEST   = (ACQ_CYC > SETTLE) ? ACQ_CYC : SETTLE;
   localparam int CNT_W     = $clog2(LONGEST + 1);
   localparam logic [CW-1:0] LAST_SEARCH = CW'(NCHORD - 2);
   localparam logic [CW-1:0] TOP_CHORD   = CW'(NCHORD - 1);

   if (NCHORD < 2 || (1 << CW) != NCHORD) begin : g_bad_chord
      $error("NCHORD must be a power of two of at least 2");
   end
   if (TAP_SHIFT < 0 || (1 << $clog2(TAP_RES)) != TAP_RES) begin : g_bad_tap
      $error("TAP_RES must be a power of two covering the step width");
   end
   if (SETTLE < 1 || ACQ_CYC < 1) begin : g_bad_time
      $error("SETTLE and ACQ_CYC must be at least 1");
   end

   phase_t          phase_q;
   logic            neg_q;
   logic [CW-1:0]   cidx_q;
   logic            expire, run, keep, lin_last;
   logic [CNT_W-1:0] len_m1;
   logic [SW-1:0]   trial, resolved;

   assign run    = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
   assign len_m1 = (phase_q == PH_ACQ) ? CNT_W'(ACQ_CYC - 1) : CNT_W'(SETTLE - 1);
   // comparator still agrees with the sign: the decision level is not yet passed
   assign keep   = (cmp_hi == !neg_q);

   seg_sar_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .len_m1(len_m1), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         neg_q   <= 1'b0;
         cidx_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE:  if (frame_tick) phase_q <= PH_ACQ;
            PH_ACQ:   if (expire) phase_q <= PH_SIGN;
            PH_SIGN:  if (expire) begin
                         neg_q   <= !cmp_hi;
                         phase_q <= PH_SETUP;
                      end
            PH_SETUP: if (expire) begin
                         cidx_q  <= '0;
                         phase_q <= PH_CHORD;
                      end
            PH_CHORD: if (expire) begin
                         if (!keep) begin
                            phase_q <= PH_LIN;
                         end else if (cidx_q == LAST_SEARCH) begin
                            cidx_q  <= TOP_CHORD;
                            phase_q <= PH_LIN;
                         end else begin
                            cidx_q  <= cidx_q + 1'b1;
                         end
                      end
            PH_LIN:   if (expire && lin_last) phase_q <= PH_DONE;
            PH_DONE:  phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   seg_sar_plates #(.NCHORD(NCHORD), .CW(CW)) i_plates (
      .phase(phase_q), .neg(neg_q), .cidx(cidx_q),
      .plate_sel(plate_sel), .pol_sw(pol_sw)
   );

   seg_sar_linear #(.SW(SW)) i_linear (
      .clk(clk), .rst_n(rst_n),
      .clear(phase_q == PH_SETUP),
      .step(phase_q == PH_LIN && expire),
      .keep(keep),
      .trial(trial), .resolved(resolved), .last(lin_last)
   );

   seg_sar_pack #(.CODE_W(CODE_W), .INVERT_OUT(INVERT_OUT)) i_pack (
      .clk(clk), .rst_n(rst_n),
      .load(phase_q == PH_LIN && expire && lin_last),
      .raw({neg_q, cidx_q, resolved}),
      .code(code_out)
   );

   assign sample_en = (phase_q == PH_ACQ);
   assign tap_en    = (phase_q == PH_LIN);
   assign tap_cap   = cidx_q;
   assign tap_code  = TAP_W'(trial) << TAP_SHIFT;
   assign done      = (phase_q == PH_DONE);
endmodule

// File: rtl/seg_sar_chk.sv
module seg_sar_chk #(
   parameter int NCHORD  = 8,
   parameter int TAP_RES = 32,
   parameter int CW      = 3,
   parameter int TAP_W   = 6,
   parameter int CODE_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_en,
   input logic              pol_sw,
   input logic [NCHORD-1:0] plate_sel,
   input logic              tap_en,
   input logic [TAP_W-1:0]  tap_code,
   input logic              done,
   input logic [CODE_W-1:0] code_out
);
   a_r2_acq_on_reference: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> (&plate_sel && pol_sw));

   a_r3_open_pol_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !pol_sw |-> !sample_en);

   a_r4_single_plate_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(plate_sel ^ $past(plate_sel)) <= 1) ||
      (plate_sel == ~$past(plate_sel)) || (&plate_sel));

   a_r6_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      tap_en |-> (!sample_en && (int'(tap_code) <= TAP_RES)));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(code_out));
endmodule

bind seg_sar_seq seg_sar_chk #(
   .NCHORD(NCHORD), .TAP_RES(TAP_RES), .CW(CW), .TAP_W(TAP_W), .CODE_W(CODE_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pol_sw(pol_sw),
   .plate_sel(plate_sel), .tap_en(tap_en), .tap_code(tap_code),
   .done(done), .code_out(code_out)
);

// File: tb/test_seg_sar_seq.sv
module test_seg_sar_seq;
   localparam int ACQ = 4;
   localparam int ST  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic       cmp_hi;
   logic       sample_en, pol_sw, tap_en, done;
   logic [7:0] plate_sel;
   logic [2:0] tap_cap;
   logic [5:0] tap_code;
   logic [7:0] code_out;

   int n_checks = 0;
   int n_fail   = 0;

   // comparator model inputs
   bit tb_neg   = 1'b0;
   int tb_chord = 0;
   int tb_step  = 0;

   always #10 clk = ~clk;

   seg_sar_seq i_seg_sar_seq (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cmp_hi(cmp_hi),
      .sample_en(sample_en), .pol_sw(pol_sw), .plate_sel(plate_sel),
      .tap_en(tap_en), .tap_cap(tap_cap), .tap_code(tap_code),
      .done(done), .code_out(code_out)
   );

   // Model: a plate counts as moved when it sits away from its start position
   // for the current sign; a fully moved array is the idle/sample position.
   always_comb begin
      int  moved;
      bit  crossed;
      moved = 0;
      for (int i = 0; i < 8; i++) if (plate_sel[i] != tb_neg) moved++;
      if (moved == 8) moved = 0;
      if (tap_en) crossed = (int'(tap_code) / 2) > tb_step;
      else        crossed = moved > tb_chord;
      cmp_hi = !tb_neg ^ crossed;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(done == 0 && sample_en == 0 && tap_en == 0, "R1 control idle",
          {done, sample_en, tap_en}, 0);
      chk(code_out == 8'h00, "R1 code reset", code_out, 0);
      chk(plate_sel == 8'hFF && pol_sw == 1, "R1 plates on reference",
          {pol_sw, plate_sel}, 9'h1FF);
   endtask

   task automatic run_conv(input bit neg, input int c, input int s, input bit poke);
      int k, acq, tapn, bad4, badcap, lat, n;
      logic [7:0] prev, diff, exp_code;
      tb_neg = neg; tb_chord = c; tb_step = s;
      n   = (c < 7) ? c + 1 : 7;
      lat = ACQ + ST * (6 + n);
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
      k = 1; acq = 0; tapn = 0; bad4 = 0; badcap = 0;
      prev = plate_sel;
      while (k < 1000) begin
         if (sample_en) acq++;
         if (tap_en) begin
            tapn++;
            if (int'(tap_cap) != c) badcap++;
         end
         diff = plate_sel ^ prev;
         if (!($countones(diff) <= 1 || diff == 8'hFF || plate_sel == 8'hFF)) bad4++;
         prev = plate_sel;
         if (k == ACQ + ST + 1) begin
            // R3: start position after the sign decision
            chk(plate_sel == (neg ? 8'hFF : 8'h00) && pol_sw == !neg,
                "R3 start position", {pol_sw, plate_sel}, {!neg, (neg ? 8'hFF : 8'h00)});
         end
         if (k == ACQ + 2 * ST + 1) begin
            // R4: first search step moves capacitor 0 only
            chk(plate_sel == (neg ? 8'hFE : 8'h01), "R4 first chord step",
                plate_sel, (neg ? 8'hFE : 8'h01));
         end
         if (done) break;
         frame_tick = (poke && k == 10);
         @(negedge clk);
         k++;
      end
      frame_tick = 1'b0;
      if (k >= 1000) chk(0, "watchdog", k, lat + 1);
      exp_code = ~{neg, 3'(c), 4'(s)};
      chk(k - 1 == lat, "R8 latency", k - 1, lat);
      chk(code_out == exp_code, "R5 R7 code", code_out, exp_code);
      chk(acq == ACQ, "R2 acquisition length", acq, ACQ);
      chk(tapn == 4 * ST && badcap == 0, "R6 tap phase", tapn, 4 * ST);
      chk(bad4 == 0, "R4 single plate moves", bad4, 0);
      @(negedge clk);
      chk(done == 0, "R7 done one cycle", done, 0);
      if (poke) begin
         acq = 0;
         for (int i = 0; i < 10; i++) begin
            if (sample_en) acq++;
            @(negedge clk);
         end
         chk(acq == 0, "R9 mid-conversion tick ignored", acq, 0);
      end
   endtask

   task automatic t_hold();
      logic [7:0] held;
      int changes;
      held = code_out; changes = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (code_out != held || done) changes++;
      end
      chk(changes == 0, "R10 code held while idle", changes, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      run_conv(1'b0, 3, 10, 1'b0);   // positive, mid chord
      run_conv(1'b1, 0, 0, 1'b0);    // negative, smallest chord, all bits cleared
      run_conv(1'b0, 7, 15, 1'b0);   // positive, saturated chord R5, all bits kept
      run_conv(1'b1, 5, 6, 1'b0);    // negative, mid chord
      run_conv(1'b1, 7, 9, 1'b0);    // negative saturation R5
      run_conv(1'b0, 6, 1, 1'b1);    // last searched capacitor flips, tick poke R9
      t_hold();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule